// File: doc/BRIEF.md
# Transmit Frame Buffer Controller

This block is the transmit half of a small memory-mapped Ethernet MAC. Software fills one of two 2 KB frame buffers through a 32-bit, word-only register bus, sets that buffer's byte count, and then writes its control word. The value written to the control word picks one of two commands. The first streams the buffer out as bytes on a valid/ready transmit interface. The second loads the 48-bit station address from the first six bytes of the buffer.

Both command bits stay set while the command is running and clear themselves when it finishes, so software can poll the control word for completion. When a command finishes, a one-cycle interrupt pulse is raised if two conditions hold: the control word has its interrupt bit set, and bit 31 of the single global enable word is set. While a command is running, any further control-word write is held off by deasserting the bus ready signal.

The sequencer has five states:
- IDLE: waiting for a command.
- SEND: streaming bytes.
- PROG_LO: fetching word 0 of the address.
- PROG_HI: fetching word 1 and loading the address.
- DONE: one cycle that clears the command bits and may pulse the interrupt.

Its transitions are:
- IDLE→SEND on a send command with a nonzero length.
- IDLE→DONE on a send command with length 0.
- IDLE→PROG_LO on a program command.
- SEND→DONE when the last byte is accepted.
- PROG_LO→PROG_HI, then PROG_HI→DONE.
- DONE→IDLE.

Top module: `txbuf_ctl`

## Requirements
- R1: After reset, tx_valid and irq are 0, mac_addr is 0, and the length, control and global enable words all read 0.
- R2: Address bit 11 selects the buffer. Within each 2 KB half, words 0x000–0x7F0 are frame data, 0x7F4 is the length and 0x7FC is the control word. 0x7F8 of buffer 0 is the global enable word. Every one of these words reads back the last value written to it.
- R3: A control write with bit 0 (S) = 1 and bit 1 (P) = 0 sends that buffer's bytes. The byte count is the low 11 bits of the length word. Bytes leave in ascending address order, least significant byte of each word first.
- R4: tx_last is high exactly on the byte at index length−1. A length of 0 sends no byte and still completes the command.
- R5: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values.
- R6: A control write with S = 1 and P = 1 loads mac_addr from the buffer's first six bytes and sends no byte. Byte 0 goes to mac_addr[47:40] and byte 5 to mac_addr[7:0].
- R7: A control write with S = 0 stores the written bits but starts no command.
- R8: S and P read as written until the command completes and read 0 afterwards. The other control bits keep their written value.
- R9: At completion, irq pulses for exactly one cycle if and only if bit 3 (I) of that buffer's control word is set and bit 31 of the global enable word is set.
- R10: Word 0xFF8 is plain storage. Setting its bit 31 does not enable interrupts.
- R11: While a command runs, a control-word write sees bus_ready low and takes effect only after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Write accepted this cycle |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| tx_last | output | 1 | Final byte of frame |
| mac_addr | output | 48 | Station address |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Sends are run with three patterns, each exposing a different class of fault:
- Odd and even lengths in each buffer, which expose byte-lane ordering and last-byte errors.
- Zero length, which separates an empty command from a one-byte one.
- Alternating and stalled tx_ready, which show whether the stream holds its data under backpressure and whether a second control write is stalled rather than lost.

Command decoding is probed with the four S/P combinations. Interrupt gating is probed by toggling the I bit, the real enable word and the look-alike word in buffer 1, so that each gating term is tested on its own.

// File: rtl/txb_pkg.sv
`timescale 1ns/1ps
package txb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_PROG_LO,
        ST_PROG_HI,
        ST_DONE
    } txb_state_e;

    localparam int CTL_START = 0;
    localparam int CTL_PROG  = 1;
    localparam int CTL_IRQ   = 3;
    localparam int GIE_BIT   = 31;
endpackage

// File: rtl/txb_regs.sv
`timescale 1ns/1ps
module txb_regs #(
    parameter int BUF_BYTES = 2048
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     sel,
    input  logic [$clog2(BUF_BYTES/4)-1:0] word,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata,
    input  logic                     fetch_buf,
    input  logic [$clog2(BUF_BYTES/4)-1:0] fetch_word,
    output logic [31:0]              fetch_data,
    input  logic                     done,
    input  logic                     done_buf,
    output logic [1:0][31:0]         len_o,
    output logic [1:0][31:0]         ctrl_o,
    output logic [31:0]              gie_o
);
    import txb_pkg::*;

    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam int WIDX_W    = $clog2(BUF_WORDS);
    localparam logic [WIDX_W-1:0] LEN_IDX = WIDX_W'(BUF_WORDS - 3);
    localparam logic [WIDX_W-1:0] GIE_IDX = WIDX_W'(BUF_WORDS - 2);
    localparam logic [WIDX_W-1:0] CTL_IDX = WIDX_W'(BUF_WORDS - 1);

    logic [31:0] mem [2][BUF_WORDS];
    logic [1:0][31:0] len_q;
    logic [1:0][31:0] ctrl_q;
    logic [31:0]      gie_q;

    // Frame storage, one bank per buffer
    for (genvar b = 0; b < 2; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (wr_en && (sel == 1'(b))) begin
                mem[b][word] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            ctrl_q <= '0;
            gie_q  <= '0;
        end else begin
            if (wr_en && word == LEN_IDX) begin
                len_q[sel] <= wdata;
            end
            if (wr_en && word == CTL_IDX) begin
                ctrl_q[sel] <= wdata;
            end
            if (wr_en && word == GIE_IDX && !sel) begin
                gie_q <= wdata;
            end
            if (done) begin
                ctrl_q[done_buf][CTL_START] <= 1'b0;
                ctrl_q[done_buf][CTL_PROG]  <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (word)
            LEN_IDX: rdata = len_q[sel];
            CTL_IDX: rdata = ctrl_q[sel];
            GIE_IDX: rdata = sel ? mem[1][word] : gie_q;
            default: rdata = mem[sel][word];
        endcase
    end

    assign fetch_data = mem[fetch_buf][fetch_word];
    assign len_o      = len_q;
    assign ctrl_o     = ctrl_q;
    assign gie_o      = gie_q;
endmodule

// File: rtl/txb_seq.sv
`timescale 1ns/1ps
module txb_seq #(
    parameter int BUF_BYTES = 2048
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     start_prog,
    input  logic                     start_buf,
    input  logic [$clog2(BUF_BYTES)-1:0] start_len,
    output logic                     busy,
    output logic                     cur_buf,
    output logic [$clog2(BUF_BYTES)-3:0] fetch_word,
    input  logic [31:0]              fetch_data,
    output logic [7:0]               tx_data,
    output logic                     tx_valid,
    output logic                     tx_last,
    input  logic                     tx_ready,
    output logic [47:0]              mac_addr,
    input  logic                     irq_en,
    output logic                     irq,
    output logic                     done
);
    import txb_pkg::*;

    localparam int LEN_W  = $clog2(BUF_BYTES);
    localparam int WIDX_W = LEN_W - 2;

    txb_state_e state, nxt;
    logic [LEN_W-1:0] idx;
    logic [LEN_W-1:0] len_q;
    logic             buf_q;
    logic [31:0]      mac_lo;
    logic [47:0]      mac_q;
    logic             at_last;

    assign at_last = (idx == len_q - LEN_W'(1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (start_prog)              nxt = ST_PROG_LO;
                    else if (start_len == '0)    nxt = ST_DONE;
                    else                         nxt = ST_SEND;
                end
            end
            ST_SEND:    if (tx_ready && at_last) nxt = ST_DONE;
            ST_PROG_LO: nxt = ST_PROG_HI;
            ST_PROG_HI: nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            len_q  <= '0;
            buf_q  <= 1'b0;
            mac_lo <= '0;
            mac_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        buf_q <= start_buf;
                        len_q <= start_len;
                        idx   <= '0;
                    end
                end
                ST_SEND:    if (tx_ready) idx <= idx + LEN_W'(1);
                ST_PROG_LO: mac_lo <= fetch_data;
                ST_PROG_HI: mac_q  <= {mac_lo[7:0], mac_lo[15:8], mac_lo[23:16],
                                       mac_lo[31:24], fetch_data[7:0], fetch_data[15:8]};
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        cur_buf    = buf_q;
        fetch_word = idx[LEN_W-1:2];
        tx_valid   = 1'b0;
        tx_last    = 1'b0;
        irq        = 1'b0;
        done       = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_SEND: begin
                tx_valid = 1'b1;
                tx_last  = at_last;
            end
            ST_PROG_LO: fetch_word = WIDX_W'(0);
            ST_PROG_HI: fetch_word = WIDX_W'(1);
            ST_DONE: begin
                done = 1'b1;
                irq  = irq_en;
            end
            default: ;
        endcase
    end

    assign tx_data  = fetch_data[{idx[1:0], 3'b000} +: 8];
    assign mac_addr = mac_q;
endmodule

// File: rtl/txbuf_ctl.sv
`timescale 1ns/1ps
module txbuf_ctl #(
    parameter int BUF_BYTES = 2048,
    localparam int ADDR_W = $clog2(BUF_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_last,
    output logic [47:0]       mac_addr,
    output logic              irq
);
    import txb_pkg::*;

    localparam int LEN_W  = $clog2(BUF_BYTES);
    localparam int WIDX_W = LEN_W - 2;
    localparam logic [WIDX_W-1:0] CTL_IDX = WIDX_W'(BUF_BYTES / 4 - 1);

    logic              sel;
    logic [WIDX_W-1:0] word;
    logic              is_ctl;
    logic              wr_en;
    logic              start;
    logic              busy;
    logic              cur_buf;
    logic              done;
    logic              irq_en;
    logic [WIDX_W-1:0] fetch_word;
    logic [31:0]       fetch_data;
    logic [1:0][31:0]  len_w;
    logic [1:0][31:0]  ctrl_w;
    logic [31:0]       gie_w;
    wire               unused_lo = ^bus_addr[1:0];

    assign sel       = bus_addr[ADDR_W-1];
    assign word      = bus_addr[ADDR_W-2:2];
    assign is_ctl    = (word == CTL_IDX);
    assign bus_ready = !(bus_valid && bus_write && is_ctl && busy);
    assign wr_en     = bus_valid && bus_write && bus_ready;
    assign start     = wr_en && is_ctl && bus_wdata[CTL_START];
    assign irq_en    = ctrl_w[cur_buf][CTL_IRQ] && gie_w[GIE_BIT];

    txb_regs #(.BUF_BYTES(BUF_BYTES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .sel        (sel),
        .word       (word),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .fetch_buf  (cur_buf),
        .fetch_word (fetch_word),
        .fetch_data (fetch_data),
        .done       (done),
        .done_buf   (cur_buf),
        .len_o      (len_w),
        .ctrl_o     (ctrl_w),
        .gie_o      (gie_w)
    );

    txb_seq #(.BUF_BYTES(BUF_BYTES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_prog (bus_wdata[CTL_PROG]),
        .start_buf  (sel),
        .start_len  (len_w[sel][LEN_W-1:0]),
        .busy       (busy),
        .cur_buf    (cur_buf),
        .fetch_word (fetch_word),
        .fetch_data (fetch_data),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_last    (tx_last),
        .tx_ready   (tx_ready),
        .mac_addr   (mac_addr),
        .irq_en     (irq_en),
        .irq        (irq),
        .done       (done)
    );
endmodule

// File: rtl/txbuf_ctl_chk.sv
`timescale 1ns/1ps
module txbuf_ctl_chk #(
    parameter int BUF_BYTES = 2048,
    localparam int ADDR_W = $clog2(BUF_BYTES) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ready,
    input logic [7:0]        tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_last,
    input logic              irq
);
    logic ctl_wr;
    assign ctl_wr = bus_valid && bus_write && (&bus_addr[ADDR_W-2:2]);

    // R4
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R5
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R9
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9
    irq_not_while_sending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !irq);

    // R11
    ctl_stalled_while_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && tx_valid) |-> !bus_ready);

    // R1
    idle_after_reset_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!tx_valid && !irq));
endmodule

bind txbuf_ctl txbuf_ctl_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (.*);

// File: tb/txbuf_ctl_bench.sv
`timescale 1ns/1ps
module txbuf_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic        tx_last;
    logic [47:0] mac_addr;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] mon_bytes [64];
    int mon_cnt = 0;
    int mon_last = -1;
    int irq_cnt = 0;
    int stall_err = 0;
    int rdy_mode = 0;
    int cyc = 0;
    logic       prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    logic       prev_last = 1'b0;

    always #2.5 clk = ~clk;

    txbuf_ctl u_txbuf_ctl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_last(tx_last), .mac_addr(mac_addr), .irq(irq)
    );

    always @(posedge clk) begin
        #1;
        cyc++;
        case (rdy_mode)
            0: tx_ready = 1'b1;
            1: tx_ready = cyc[0];
            default: tx_ready = 1'b0;
        endcase
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall && (!tx_valid || tx_data != prev_data || tx_last != prev_last))
                stall_err++;
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            prev_last  = tx_last;
            if (tx_valid && tx_ready) begin
                if (mon_cnt < 64) mon_bytes[mon_cnt] = tx_data;
                if (tx_last) mon_last = mon_cnt;
                mon_cnt++;
            end
            if (irq) irq_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (bus_ready) break;
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        @(posedge clk); #1;
    endtask

    task automatic wait_idle(input logic [11:0] ctl_addr);
        logic [31:0] v;
        for (int i = 0; i < 500; i++) begin
            rd(ctl_addr, v);
            if (!v[0]) break;
        end
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic clear_mon();
        mon_cnt = 0; mon_last = -1; irq_cnt = 0; stall_err = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk(tx_valid == 1'b0, "R1", "tx_valid", tx_valid, 0);
        chk(irq == 1'b0, "R1", "irq", irq, 0);
        chk(mac_addr == 48'h0, "R1", "mac_addr", mac_addr, 0);
        rd(12'h7FC, v); chk(v == 0, "R1", "ctrl0", v, 0);
        rd(12'hFF4, v); chk(v == 0, "R1", "len1", v, 0);
        rd(12'h7F8, v); chk(v == 0, "R1", "gie", v, 0);
        wr(12'h010, 32'hCAFE0123);
        wr(12'hFF4, 32'h0000_0123);
        rd(12'h010, v); chk(v == 32'hCAFE0123, "R2", "data readback", v, 32'hCAFE0123);
        rd(12'hFF4, v); chk(v == 32'h123, "R2", "len1 readback", v, 32'h123);
    endtask

    task automatic t_send0();
        logic [31:0] v;
        clear_mon();
        wr(12'h000, 32'h44332211);
        wr(12'h004, 32'h00000055);
        wr(12'h7F4, 32'd5);
        wr(12'h7F8, 32'h80000000);
        wr(12'h7FC, 32'h9);
        wait_idle(12'h7FC);
        chk(mon_cnt == 5, "R3", "send0 count", mon_cnt, 5);
        for (int i = 0; i < 5; i++)
            chk(mon_bytes[i] == 8'(8'h11 * (i + 1)), "R3", "send0 byte", mon_bytes[i], 8'(8'h11 * (i + 1)));
        chk(mon_last == 4, "R4", "send0 last index", mon_last, 4);
        chk(irq_cnt == 1, "R9", "send0 irq pulses", irq_cnt, 1);
        rd(12'h7FC, v); chk(v == 32'h8, "R8", "ctrl0 after send", v, 32'h8);
    endtask

    task automatic t_send1_noirq();
        clear_mon();
        wr(12'h800, 32'h04030201);
        wr(12'h804, 32'h00000605);
        wr(12'hFF4, 32'd6);
        wr(12'hFFC, 32'h1);
        wait_idle(12'hFFC);
        chk(mon_cnt == 6, "R3", "send1 count", mon_cnt, 6);
        chk(mon_bytes[5] == 8'h06 && mon_bytes[0] == 8'h01, "R3", "send1 ends",
            {mon_bytes[0], mon_bytes[5]}, 16'h0106);
        chk(mon_last == 5, "R4", "send1 last index", mon_last, 5);
        chk(irq_cnt == 0, "R9", "no irq without I", irq_cnt, 0);
    endtask

    task automatic t_prog();
        logic [31:0] v;
        clear_mon();
        wr(12'h800, 32'hDDCCBBAA);
        wr(12'h804, 32'h0000FFEE);
        wr(12'hFFC, 32'hB);
        wait_idle(12'hFFC);
        chk(mac_addr == 48'hAABBCCDDEEFF, "R6", "station address", mac_addr, 48'hAABBCCDDEEFF);
        chk(mon_cnt == 0, "R6", "program sends nothing", mon_cnt, 0);
        chk(irq_cnt == 1, "R9", "program irq", irq_cnt, 1);
        rd(12'hFFC, v); chk(v == 32'h8, "R8", "ctrl1 after program", v, 32'h8);
    endtask

    task automatic t_gie();
        logic [31:0] v;
        clear_mon();
        wr(12'h7F8, 32'h0);
        wr(12'h7F4, 32'd1);
        wr(12'h7FC, 32'h9);
        wait_idle(12'h7FC);
        chk(irq_cnt == 0, "R9", "global enable off", irq_cnt, 0);
        clear_mon();
        wr(12'hFF8, 32'h80000000);
        wr(12'hFF4, 32'd1);
        wr(12'hFFC, 32'h9);
        wait_idle(12'hFFC);
        chk(irq_cnt == 0, "R10", "buffer1 enable word ignored", irq_cnt, 0);
        chk(mon_cnt == 1, "R10", "frame still sent", mon_cnt, 1);
        rd(12'hFF8, v); chk(v == 32'h80000000, "R10", "0xFF8 storage", v, 32'h80000000);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        clear_mon();
        wr(12'h7F8, 32'h80000000);
        wr(12'h7F4, 32'd0);
        wr(12'h7FC, 32'h9);
        wait_idle(12'h7FC);
        chk(mon_cnt == 0, "R4", "zero length bytes", mon_cnt, 0);
        chk(irq_cnt == 1, "R4", "zero length completes", irq_cnt, 1);
        rd(12'h7FC, v); chk(v == 32'h8, "R4", "zero length S cleared", v, 32'h8);
    endtask

    task automatic t_backpressure();
        clear_mon();
        rdy_mode = 1;
        wr(12'h000, 32'h44332211);
        wr(12'h004, 32'h00776655);
        wr(12'h7F4, 32'd7);
        wr(12'h7FC, 32'h1);
        wait_idle(12'h7FC);
        rdy_mode = 0;
        chk(mon_cnt == 7, "R5", "stalled count", mon_cnt, 7);
        chk(mon_bytes[6] == 8'h77, "R5", "stalled byte6", mon_bytes[6], 8'h77);
        chk(stall_err == 0, "R5", "hold while stalled", stall_err, 0);
        chk(mon_last == 6, "R4", "stalled last", mon_last, 6);
    endtask

    task automatic t_nocmd();
        logic [31:0] v;
        logic [47:0] m;
        clear_mon();
        m = mac_addr;
        wr(12'h7F4, 32'd3);
        wr(12'h7FC, 32'h8);
        repeat (6) @(posedge clk);
        #1;
        chk(mon_cnt == 0, "R7", "S=0 sends nothing", mon_cnt, 0);
        wr(12'h7FC, 32'h2);
        repeat (6) @(posedge clk);
        #1;
        chk(mac_addr == m, "R7", "P only leaves address", mac_addr, m);
        rd(12'h7FC, v); chk(v == 32'h2, "R7", "P only stored", v, 32'h2);
    endtask

    task automatic t_holdoff();
        logic [31:0] v;
        int lows;
        clear_mon();
        rdy_mode = 2;
        wr(12'h7F4, 32'd4);
        wr(12'h7FC, 32'h1);
        rd(12'h7FC, v); chk(v[1:0] == 2'b01, "R8", "S set while busy", v[1:0], 2'b01);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'hFFC; bus_wdata = 32'hC;
        lows = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!bus_ready) lows++;
            @(posedge clk); #1;
        end
        chk(lows == 4, "R11", "ctrl write stalled", lows, 4);
        rdy_mode = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (bus_ready) break;
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
        wait_idle(12'h7FC);
        chk(mon_cnt == 4, "R11", "first frame intact", mon_cnt, 4);
        rd(12'hFFC, v); chk(v == 32'hC, "R11", "held write landed", v, 32'hC);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_send0();
        t_send1_noirq();
        t_prog();
        t_gie();
        t_zero();
        t_backpressure();
        t_nocmd();
        t_holdoff();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule